// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This peripheral watches over software by counting down from a programmable value. Software reaches it through a plain register bus: an address, a write strobe, write data, and combinational read data. A single control bit starts the counter and also enables the interrupt. Once set, that bit stays set until system reset.

When the count first reaches zero, the interrupt is raised and the counter reloads. Servicing the interrupt means writing to the clear register. If software fails to do so, the next expiry finds the interrupt still pending. With reset generation enabled, that second expiry emits a one-cycle reset request to the processor.

A lock register guards the control and load registers. Any write of a value other than the key engages the lock, and writing the key releases it. While the lock is held, configuration writes are dropped without any response. The clear register stays writable while locked, so a locked system can still be serviced.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control word reads 0, the load and value registers read all ones, status reads 0, the lock register reads 0 (unlocked), and irq_o and rst_req_o are low.
- R2: While stopped, the counter holds its value. Writing the control word (word 0) with bit 0 set starts the counter, which takes the load value at that edge. Bit 0 reads back as 1 from then on, even if a later write puts 0 in that bit. Bit 1 of the control word is the reset enable and reads back as written.
- R3: While running, the counter (word 2) drops by one per clock. On the edge where it is zero, it reloads from the load register (word 1), and irq_o rises if it was low. The timeout period is therefore load+1 cycles.
- R4: A timeout that finds irq_o already high, with reset enable set, drives rst_req_o high for exactly one cycle. On that edge the counter reloads and irq_o stays high.
- R5: With reset enable clear, a timeout that finds irq_o high does not assert rst_req_o. The counter still reloads.
- R6: An accepted write to the load register while running puts the written value into the counter on the same edge.
- R7: An accepted write of zero to the load register while running raises irq_o on that edge.
- R8: Any write to the clear register (word 3) lowers irq_o and reloads the counter from the load register on the same edge. This works whether or not the lock is engaged.
- R9: A lock register (word 5) write of 32'h1ACCE551 releases the lock, and a write of any other value engages it. The register reads 1 when locked and 0 when unlocked, and reset releases the lock.
- R10: While locked, writes to the control and load registers change nothing.
- R11: The status register (word 4) reads irq_o in bit 0 with zeros above. The clear register and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Pending timeout interrupt |
| rst_req_o | output | 1 | One-cycle processor reset request |

## Verification
Every write takes effect on the clock edge that samples it. Register reads are combinational from state, so a write's result can be read one cycle after the write. The counter value follows a fixed cycle count from the starting edge: the first timeout lands load+1 edges after the start, and the reset pulse lands another load+1 edges later. The bench drives stimulus and queues its expectations at the falling edge. A monitor compares read data, irq_o and rst_req_o a quarter period later, one expectation per cycle, so each check falls in the exact cycle computed from those latencies.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_LOAD   = 3'd1,
    REG_VALUE  = 3'd2,
    REG_ICLR   = 3'd3,
    REG_STATUS = 3'd4,
    REG_LOCK   = 3'd5
  } wdog_reg_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_RST_BIT = 1;
endpackage

// File: rtl/wdog_lock.sv
module wdog_lock #(
  parameter int unsigned DW = wdog_pkg::DATA_W,
  parameter logic [DW-1:0] KEY = wdog_pkg::UNLOCK_KEY
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lock_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o
);
  logic locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        locked_q <= 1'b0;
    else if (we_lock_i) locked_q <= (wdata_i != KEY);
  end

  assign locked_o = locked_q;

  a_r9_key_unlocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lock_i && wdata_i == KEY) |=> !locked_o);
  a_r9_other_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_lock_i && wdata_i != KEY) |=> locked_o);
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg #(
  parameter int unsigned DW = wdog_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_ctrl_i,
  input  logic          we_load_i,
  input  logic          locked_i,
  input  logic [DW-1:0] wdata_i,
  output logic          run_o,
  output logic          rsten_o,
  output logic [DW-1:0] load_o,
  output logic          start_o,
  output logic          load_wr_o
);
  import wdog_pkg::*;

  logic          run_q, rsten_q;
  logic [DW-1:0] load_q;
  logic          ctrl_ok;

  assign ctrl_ok   = we_ctrl_i && !locked_i;
  assign load_wr_o = we_load_i && !locked_i;
  assign start_o   = ctrl_ok && wdata_i[CTRL_RUN_BIT] && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rsten_q <= 1'b0;
    end else if (ctrl_ok) begin
      run_q   <= run_q | wdata_i[CTRL_RUN_BIT];  // run is sticky
      rsten_q <= wdata_i[CTRL_RST_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        load_q <= '1;
    else if (load_wr_o) load_q <= wdata_i;
  end

  assign run_o   = run_q;
  assign rsten_o = rsten_q;
  assign load_o  = load_q;

  a_r2_run_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |=> run_o);
  a_r10_load_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_load_i && locked_i) |=> $stable(load_o));
  a_r10_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_ctrl_i && locked_i) |=> ($stable(rsten_o) && $stable(run_o)));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned DW = wdog_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          start_i,
  input  logic          load_wr_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] load_i,
  output logic [DW-1:0] cnt_o,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic          reload;

  assign tick_o = run_i && (cnt_q == '0) && !load_wr_i;
  assign reload = clr_i || tick_o || start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '1;
    else if (load_wr_i && run_i)  cnt_q <= wdata_i;  // immediate copy
    else if (reload)              cnt_q <= load_i;
    else if (run_i)               cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_o != '0 && !load_wr_i && !clr_i && !start_i)
      |=> cnt_o == $past(cnt_o) - 1'b1);
  a_r2_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !start_i && !clr_i) |=> $stable(cnt_o));
  a_r6_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && load_wr_i) |=> cnt_o == $past(wdata_i));
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic event_i,
  input  logic clr_i,
  input  logic rsten_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= event_i && irq_q && rsten_i && !clr_i;
      if (clr_i)        irq_q <= 1'b0;
      else if (event_i) irq_q <= 1'b1;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r4_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> irq_o);
  a_r5_no_rst_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsten_i |=> !rst_req_o);
  a_r8_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !irq_o);
  a_r3_first_raises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i && !clr_i) |=> irq_o);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  logic we_ctrl, we_load, we_clr, we_lock;
  logic locked, run, rsten, start, load_wr, tick, zero_hit, ev;
  logic [DATA_W-1:0] load_v, cnt_v;

  assign we_ctrl = we_i && (addr_i == REG_CTRL);
  assign we_load = we_i && (addr_i == REG_LOAD);
  assign we_clr  = we_i && (addr_i == REG_ICLR);
  assign we_lock = we_i && (addr_i == REG_LOCK);

  wdog_lock #(.DW(DATA_W)) u_lock (
    .clk_i, .rst_ni, .we_lock_i(we_lock), .wdata_i, .locked_o(locked)
  );

  wdog_cfg #(.DW(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .we_ctrl_i(we_ctrl), .we_load_i(we_load),
    .locked_i(locked), .wdata_i, .run_o(run), .rsten_o(rsten),
    .load_o(load_v), .start_o(start), .load_wr_o(load_wr)
  );

  wdog_counter #(.DW(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .start_i(start), .load_wr_i(load_wr),
    .clr_i(we_clr), .wdata_i, .load_i(load_v), .cnt_o(cnt_v), .tick_o(tick)
  );

  // zero load while running counts as an immediate timeout
  assign zero_hit = load_wr && run && (wdata_i == '0);
  assign ev       = tick || zero_hit;

  wdog_stage u_stage (
    .clk_i, .rst_ni, .event_i(ev), .clr_i(we_clr), .rsten_i(rsten),
    .irq_o, .rst_req_o
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_RUN_BIT] = run;
        rdata_o[CTRL_RST_BIT] = rsten;
      end
      REG_LOAD:   rdata_o = load_v;
      REG_VALUE:  rdata_o = cnt_v;
      REG_STATUS: rdata_o[0] = irq_o;
      REG_LOCK:   rdata_o[0] = locked;
      default:    rdata_o = '0;
    endcase
  end

  a_r7_zero_load_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_load && !locked && run && wdata_i == '0 && !we_clr) |=> irq_o);
endmodule

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;
  localparam time CLK_P = 10ns;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_VAL = 3'd2,
                         A_CLR = 3'd3, A_STAT = 3'd4, A_LOCK = 3'd5;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, rreq;

  typedef struct {
    logic        chk_rd;
    logic [31:0] rd;
    logic        irq;
    logic        rst;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wdog_two_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .rst_req_o(rreq)
  );

  // monitor: one expectation per cycle, sampled a quarter period after negedge
  always @(negedge clk) begin
    #(CLK_P/4);
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (irq !== it.irq) begin
        n_bad++;
        $display("FAIL %s irq_o act=%b exp=%b", it.req, irq, it.irq);
      end
      n_chk++;
      if (rreq !== it.rst) begin
        n_bad++;
        $display("FAIL %s rst_req_o act=%b exp=%b", it.req, rreq, it.rst);
      end
      if (it.chk_rd) begin
        n_chk++;
        if (rdata !== it.rd) begin
          n_bad++;
          $display("FAIL %s rdata act=%h exp=%h", it.req, rdata, it.rd);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic probe(input logic [2:0] a, input logic [31:0] e,
                       input logic ei, input logic er, input string req);
    item_t it;
    @(negedge clk);
    addr = a; we = 1'b0;
    it.chk_rd = 1'b1; it.rd = e; it.irq = ei; it.rst = er; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*5000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    probe(A_CTRL, 32'h0, 0, 0, "R1");
    probe(A_LOAD, 32'hFFFF_FFFF, 0, 0, "R1");
    probe(A_VAL,  32'hFFFF_FFFF, 0, 0, "R1/R2 hold");
    probe(A_LOCK, 32'h0, 0, 0, "R1");
    probe(A_VAL,  32'hFFFF_FFFF, 0, 0, "R2 hold stopped");
    probe(A_STAT, 32'h0, 0, 0, "R11");

    // R2/R3/R4: load 5, run + reset enable
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'd3);
    for (int n = 0; n < 6; n++) probe(A_VAL, 32'(5 - n), 0, 0, "R3 count");
    probe(A_VAL, 32'd5, 1, 0, "R3 first timeout");
    for (int n = 1; n < 6; n++) probe(A_VAL, 32'(5 - n), 1, 0, "R3 second period");
    probe(A_VAL, 32'd5, 1, 1, "R4 reset pulse");
    probe(A_VAL, 32'd4, 1, 0, "R4 single cycle");
    probe(A_CTRL, 32'd3, 1, 0, "R2 ctrl readback");

    // R8 clear
    wr(A_CLR, 32'h0);
    probe(A_VAL, 32'd5, 0, 0, "R8 clear reload");
    // R6 immediate copy
    wr(A_LOAD, 32'd100);
    probe(A_VAL, 32'd100, 0, 0, "R6 copy");
    probe(A_VAL, 32'd99, 0, 0, "R6 then count");
    // R9/R10 lock
    wr(A_LOCK, 32'h0);
    probe(A_LOCK, 32'd1, 0, 0, "R9 locked");
    wr(A_LOAD, 32'd7);
    probe(A_LOAD, 32'd100, 0, 0, "R10 load ignored");
    wr(A_CTRL, 32'd0);
    probe(A_CTRL, 32'd3, 0, 0, "R10 ctrl ignored");
    wr(A_CLR, 32'h1234);
    probe(A_VAL, 32'd100, 0, 0, "R8 clear while locked");
    probe(A_CLR, 32'd0, 0, 0, "R11 clear reads zero");
    wr(A_LOCK, KEY);
    probe(A_LOCK, 32'd0, 0, 0, "R9 unlocked");
    wr(A_CTRL, 32'd0);
    probe(A_CTRL, 32'd1, 0, 0, "R2 run sticky");

    // R5 second timeout without reset enable
    wr(A_LOAD, 32'd3);
    for (int n = 0; n < 4; n++) probe(A_VAL, 32'(3 - n), 0, 0, "R5 count");
    probe(A_VAL, 32'd3, 1, 0, "R5 first timeout");
    for (int n = 1; n < 4; n++) probe(A_VAL, 32'(3 - n), 1, 0, "R5 count");
    probe(A_VAL, 32'd3, 1, 0, "R5 no reset");
    wr(A_CLR, 32'h0);
    probe(A_STAT, 32'd0, 0, 0, "R8/R11 status cleared");

    // R7 zero load
    wr(A_LOAD, 32'd0);
    probe(A_STAT, 32'd1, 1, 0, "R7/R11 zero load irq");
    probe(A_VAL, 32'd0, 1, 0, "R7 hold zero");

    // R9 reset releases lock
    wr(A_LOCK, 32'h55);
    probe(A_LOCK, 32'd1, 1, 0, "R9 relock");
    @(negedge clk);
    rst_n = 1'b0;
    probe(A_LOCK, 32'd0, 0, 0, "R9/R1 reset unlocks");
    probe(A_CTRL, 32'd0, 0, 0, "R1 ctrl after reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    summary();
  end
endmodule